// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers up to eighty peripheral interrupt lines, numbered as vectors 2 through 81, and turns them into a single request to a processor core. Software gives every line a two-bit priority code through a small word-addressed register port. A pulse on a line sets a sticky pending bit. The bit stays set until the core acknowledges that vector. Each cycle, combinational arbitration picks the most urgent enabled pending line. The block presents its level, its vector number and the address the core should fetch from.

The fetch address normally comes from a vector table: a programmable base plus two words per vector. Two fast slots can each name one vector and give it a full direct address. That address is used only when the vector wins at the top peripheral level. While reset is active, and for a short window after it ends, the block drives a fixed reset address and holds the request low. A status register records the vector number of the last acknowledged interrupt.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Each source k (vector k+2) has a 2-bit priority code at register k/8, bits [2(k%8)+1 : 2(k%8)]. Code 00 disables the source. Codes 01, 10 and 11 select levels 0, 1 and 2. All codes reset to 00, and a disabled source never wins.
- R2: A high cycle on `irq_in[k]` sets pending bit k, which holds until acknowledged. Pending bits read at register 17 + k/16, bit k%16, and all reset to 0.
- R3: The winner is the pending, enabled source with the highest level. Among equal levels the lowest vector number wins. `irq_lvl` gives the winner's level (0..2) and `vec_num` its vector number.
- R4: `irq_req` is high only when a winner exists and its level is greater than or equal to `core_mask`. A mask of 3 blocks every source.
- R5: The table address is base*256 + 2*vector, taken modulo 2^21. The 13-bit base sits in register 10.
- R6: Fast slot s (s = 0, 1) uses register 11+3s for its 7-bit vector match, 12+3s for address bits [15:0] and 13+3s for address bits [20:16]. When the winner is at level 2 and matches a slot, `vec_addr` is that slot's address, and slot 0 takes precedence over slot 1. At lower levels the table address is used.
- R7: While `rst` is high, and until the second rising clock edge after it falls, `vec_addr` equals `RESET_ADDR` and `irq_req` is low.
- R8: If `core_ack` is high on an edge where `irq_req` is high, the winner's pending bit clears, unless its line is high on that edge. The winner's vector number is then loaded into the status register at address 22. An acknowledge without a request has no effect.
- R9: Writes to the pending registers, to the status register and to unmapped addresses (23 and up) have no effect. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 80 | Peripheral interrupt lines, bit k is vector k+2 |
| core_mask | input | 2 | Core's current interrupt mask level |
| core_ack | input | 1 | Core takes the presented interrupt |
| irq_req | output | 1 | Interrupt request to the core |
| irq_lvl | output | 2 | Level of the winning request |
| vec_num | output | 7 | Vector number of the winning request |
| vec_addr | output | 21 | Fetch address for the core |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |

## Verification
The inline assertions watch, on every cycle, several rules that must always hold:
- a request never goes out below the mask or at level 3;
- the winner is always pending and enabled;
- no enabled pending line goes unserved;
- an acknowledge clears its bit and updates the status register;
- the reset address is driven on the first cycle after reset.

Other behaviours need the bench's scenarios, which compare against a reference model:
- the tie-break toward the lowest vector;
- the exact table and fast-slot addresses, and slot precedence;
- the length of the post-reset window;
- the silence of read-only and unmapped registers under writes.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int NUM_SRC     = 80;
    localparam int FIRST_VEC   = 2;
    localparam int VEC_W       = 7;
    localparam int IDX_W       = $clog2(NUM_SRC);
    localparam int ADDR_W      = 21;
    localparam int DATA_W      = 16;
    localparam int PRIO_W      = 2;
    localparam int NUM_LVL     = 3;
    localparam int NUM_FAST    = 2;
    localparam int FLD_PER_REG = DATA_W / PRIO_W;
    localparam int PRIO_REGS   = (NUM_SRC + FLD_PER_REG - 1) / FLD_PER_REG;
    localparam int PEND_REGS   = (NUM_SRC + DATA_W - 1) / DATA_W;
    localparam int VBASE_W     = ADDR_W - 8;
    localparam int HI_W        = ADDR_W - DATA_W;
    localparam int REG_AW      = 5;
    localparam int REG_VBASE   = PRIO_REGS;
    localparam int REG_FAST0   = PRIO_REGS + 1;
    localparam int REG_PEND0   = REG_FAST0 + 3 * NUM_FAST;
    localparam int REG_LAST    = REG_PEND0 + PEND_REGS;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [1:0]        lvl_t;

    typedef struct packed {
        logic             valid;
        lvl_t             lvl;
        logic [IDX_W-1:0] idx;
    } win_t;

    typedef struct packed {
        logic [VEC_W-1:0]  match;
        logic [ADDR_W-1:0] addr;
    } fast_t;

    // priority code -> one-hot level (bit 0 = level 0), zero when disabled
    function automatic logic [NUM_LVL-1:0] prio_onehot(prio_t code);
        case (code)
            2'b01:   return 3'b001;
            2'b10:   return 3'b010;
            2'b11:   return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

    function automatic lvl_t prio_level(prio_t code);
        return code - 2'd1;
    endfunction
endpackage

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic [REG_AW-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    output prio_t [NUM_SRC-1:0]          prio_o,
    output logic [VBASE_W-1:0]           vbase_o,
    output fast_t [NUM_FAST-1:0]         fast_o
);
    logic [PRIO_REGS-1:0][DATA_W-1:0] prio_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prio_q  <= '0;
            vbase_o <= '0;
            fast_o  <= '0;
        end else if (we) begin
            for (int r = 0; r < PRIO_REGS; r++)
                if (addr == REG_AW'(r)) prio_q[r] <= wdata;
            if (addr == REG_AW'(REG_VBASE)) vbase_o <= wdata[VBASE_W-1:0];
            for (int s = 0; s < NUM_FAST; s++) begin
                if (addr == REG_AW'(REG_FAST0 + 3 * s))
                    fast_o[s].match <= wdata[VEC_W-1:0];
                if (addr == REG_AW'(REG_FAST0 + 3 * s + 1))
                    fast_o[s].addr[DATA_W-1:0] <= wdata;
                if (addr == REG_AW'(REG_FAST0 + 3 * s + 2))
                    fast_o[s].addr[ADDR_W-1:DATA_W] <= wdata[HI_W-1:0];
            end
        end
    end

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_field
        assign prio_o[k] = prio_q[k / FLD_PER_REG][(k % FLD_PER_REG) * PRIO_W +: PRIO_W];
    end

    assert_vbase_write_R5: assert property (@(posedge clk) disable iff (rst)
        (we && addr == REG_AW'(REG_VBASE)) |=> vbase_o == $past(wdata[VBASE_W-1:0]));
endmodule

// File: rtl/pic_pending.sv
module pic_pending
    import pic_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic               clr_i,
    input  logic [IDX_W-1:0]   clr_idx_i,
    output logic [NUM_SRC-1:0] pend_o
);
    logic [NUM_SRC-1:0] clr_mask;

    always_comb begin
        clr_mask = '0;
        if (clr_i && int'(clr_idx_i) < NUM_SRC) clr_mask[clr_idx_i] = 1'b1;
    end

    // a new pulse on the same edge as the clear keeps the bit set
    always_ff @(posedge clk) begin
        if (rst) pend_o <= '0;
        else     pend_o <= (pend_o & ~clr_mask) | set_i;
    end

    assert_pulse_latched_R2: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (clr_i && int'(clr_idx_i) < NUM_SRC && !set_i[clr_idx_i]) |=> !pend_o[$past(clr_idx_i)]);
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
    import pic_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] pend_i,
    input  prio_t [NUM_SRC-1:0] prio_i,
    output win_t               win_o
);
    logic [NUM_SRC-1:0][NUM_LVL-1:0] oh;
    logic [NUM_SRC-1:0]              en_vec;

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_dec
        assign oh[k]     = pend_i[k] ? prio_onehot(prio_i[k]) : '0;
        assign en_vec[k] = prio_i[k] != '0;
    end

    always_comb begin
        logic [NUM_LVL-1:0] any;
        lvl_t               top;
        any = '0;
        for (int k = 0; k < NUM_SRC; k++) any = any | oh[k];
        if (any[2])      top = 2'd2;
        else if (any[1]) top = 2'd1;
        else             top = 2'd0;
        win_o       = '0;
        win_o.valid = |any;
        win_o.lvl   = top;
        // scan downward so the lowest index at the top level is kept
        for (int k = NUM_SRC - 1; k >= 0; k--)
            if (oh[k][top]) win_o.idx = IDX_W'(k);
    end

    assert_win_enabled_R1: assert property (@(posedge clk) disable iff (rst)
        win_o.valid |-> (pend_i[win_o.idx] && prio_i[win_o.idx] != '0
                         && prio_level(prio_i[win_o.idx]) == win_o.lvl));

    assert_no_lost_req_R3: assert property (@(posedge clk) disable iff (rst)
        ((pend_i & en_vec) != '0) |-> win_o.valid);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_ADDR = 21'h0F0000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [1:0]         core_mask,
    input  logic               core_ack,
    output logic               irq_req,
    output logic [1:0]         irq_lvl,
    output logic [VEC_W-1:0]   vec_num,
    output logic [ADDR_W-1:0]  vec_addr,
    input  logic               reg_we,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata
);
    prio_t [NUM_SRC-1:0]  prio;
    logic [VBASE_W-1:0]   vbase;
    fast_t [NUM_FAST-1:0] fast;
    logic [NUM_SRC-1:0]   pend;
    win_t                 win;
    logic [1:0]           hold_q;
    logic                 in_reset;
    logic                 take;
    logic [VEC_W-1:0]     win_vec;
    logic [VEC_W-1:0]     last_q;
    logic                 fast_hit;
    logic [ADDR_W-1:0]    fast_addr;
    logic [ADDR_W-1:0]    tbl_addr;

    pic_regs u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .prio_o(prio), .vbase_o(vbase), .fast_o(fast)
    );

    pic_pending u_pend (
        .clk(clk), .rst(rst), .set_i(irq_in), .clr_i(take),
        .clr_idx_i(win.idx), .pend_o(pend)
    );

    pic_arbiter u_arb (
        .clk(clk), .rst(rst), .pend_i(pend), .prio_i(prio), .win_o(win)
    );

    // reset address window: reset plus two edges after release
    always_ff @(posedge clk) begin
        if (rst)                 hold_q <= 2'd2;
        else if (hold_q != 2'd0) hold_q <= hold_q - 2'd1;
    end

    assign in_reset = rst || (hold_q != 2'd0);
    assign win_vec  = VEC_W'(win.idx) + VEC_W'(FIRST_VEC);
    assign irq_req  = win.valid && (win.lvl >= core_mask) && !in_reset;
    assign irq_lvl  = win.lvl;
    assign vec_num  = win_vec;
    assign take     = core_ack && irq_req;
    assign tbl_addr = {vbase, 8'b0} + ADDR_W'({win_vec, 1'b0});

    always_comb begin
        fast_hit  = 1'b0;
        fast_addr = '0;
        for (int s = NUM_FAST - 1; s >= 0; s--)
            if (win.lvl == 2'd2 && win_vec == fast[s].match) begin
                fast_hit  = 1'b1;
                fast_addr = fast[s].addr;
            end
    end

    assign vec_addr = in_reset ? RESET_ADDR : (fast_hit ? fast_addr : tbl_addr);

    always_ff @(posedge clk) begin
        if (rst)       last_q <= '0;
        else if (take) last_q <= win_vec;
    end

    always_comb begin
        int a;
        int k;
        int s;
        int sub;
        a   = int'(reg_addr);
        k   = 0;
        s   = 0;
        sub = 0;
        reg_rdata = '0;
        if (a < PRIO_REGS) begin
            for (int f = 0; f < FLD_PER_REG; f++) begin
                k = a * FLD_PER_REG + f;
                if (k < NUM_SRC) reg_rdata[f * PRIO_W +: PRIO_W] = prio[k];
            end
        end else if (a == REG_VBASE) begin
            reg_rdata[VBASE_W-1:0] = vbase;
        end else if (a >= REG_FAST0 && a < REG_PEND0) begin
            s   = (a - REG_FAST0) / 3;
            sub = (a - REG_FAST0) % 3;
            if (sub == 0)      reg_rdata[VEC_W-1:0] = fast[s].match;
            else if (sub == 1) reg_rdata = fast[s].addr[DATA_W-1:0];
            else               reg_rdata[HI_W-1:0] = fast[s].addr[ADDR_W-1:DATA_W];
        end else if (a >= REG_PEND0 && a < REG_LAST) begin
            for (int b = 0; b < DATA_W; b++) begin
                k = (a - REG_PEND0) * DATA_W + b;
                if (k < NUM_SRC) reg_rdata[b] = pend[k];
            end
        end else if (a == REG_LAST) begin
            reg_rdata[VEC_W-1:0] = last_q;
        end
    end

    assert_req_mask_R4: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_lvl >= core_mask && irq_lvl != 2'd3));

    assert_reset_vec_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (vec_addr == RESET_ADDR && !irq_req));

    assert_status_load_R8: assert property (@(posedge clk) disable iff (rst)
        (core_ack && irq_req) |=> last_q == $past(vec_num));
endmodule

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
    import pic_pkg::*;

    localparam logic [ADDR_W-1:0] RST_A = 21'h0F0000;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NUM_SRC-1:0] irq_in = '0;
    logic [1:0]         core_mask = 2'd0;
    logic               core_ack = 1'b0;
    logic               irq_req;
    logic [1:0]         irq_lvl;
    logic [VEC_W-1:0]   vec_num;
    logic [ADDR_W-1:0]  vec_addr;
    logic               reg_we = 1'b0;
    logic [REG_AW-1:0]  reg_addr = '0;
    logic [DATA_W-1:0]  reg_wdata = '0;
    logic [DATA_W-1:0]  reg_rdata;

    prio_irq_ctrl #(.RESET_ADDR(RST_A)) dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .core_mask(core_mask),
        .core_ack(core_ack), .irq_req(irq_req), .irq_lvl(irq_lvl),
        .vec_num(vec_num), .vec_addr(vec_addr), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    int m_prio [NUM_SRC];
    bit m_pend [NUM_SRC];
    int m_vbase, m_last, m_hold;
    int m_match [NUM_FAST];
    int m_lo    [NUM_FAST];
    int m_hi    [NUM_FAST];

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic void m_reset();
        for (int k = 0; k < NUM_SRC; k++) begin m_prio[k] = 0; m_pend[k] = 0; end
        for (int s = 0; s < NUM_FAST; s++) begin m_match[s] = 0; m_lo[s] = 0; m_hi[s] = 0; end
        m_vbase = 0;
        m_last  = 0;
        m_hold  = 2;
    endfunction

    function automatic void calc_win(output bit v, output int lvl, output int idx);
        v = 0; lvl = 0; idx = 0;
        for (int l = 2; l >= 0 && !v; l--)
            for (int k = 0; k < NUM_SRC && !v; k++)
                if (m_pend[k] && m_prio[k] == l + 1) begin v = 1; lvl = l; idx = k; end
    endfunction

    function automatic int calc_addr(int lvl, int vec, output bit fast);
        fast = 0;
        for (int s = 0; s < NUM_FAST; s++)
            if (lvl == 2 && vec == m_match[s]) begin
                fast = 1;
                return (m_hi[s] << 16) | m_lo[s];
            end
        return ((m_vbase << 8) + vec * 2) & 32'h1FFFFF;
    endfunction

    function automatic int calc_read(int a);
        int r = 0;
        if (a < PRIO_REGS) begin
            for (int f = 0; f < FLD_PER_REG; f++)
                if (a * FLD_PER_REG + f < NUM_SRC) r |= m_prio[a * FLD_PER_REG + f] << (2 * f);
        end else if (a == REG_VBASE) r = m_vbase;
        else if (a >= REG_FAST0 && a < REG_PEND0) begin
            case ((a - REG_FAST0) % 3)
                0: r = m_match[(a - REG_FAST0) / 3];
                1: r = m_lo[(a - REG_FAST0) / 3];
                default: r = m_hi[(a - REG_FAST0) / 3];
            endcase
        end else if (a >= REG_PEND0 && a < REG_LAST) begin
            for (int b = 0; b < DATA_W; b++)
                if ((a - REG_PEND0) * DATA_W + b < NUM_SRC && m_pend[(a - REG_PEND0) * DATA_W + b])
                    r |= 1 << b;
        end else if (a == REG_LAST) r = m_last;
        return r;
    endfunction

    function automatic void m_write(int a, int d);
        if (a < PRIO_REGS) begin
            for (int f = 0; f < FLD_PER_REG; f++)
                if (a * FLD_PER_REG + f < NUM_SRC) m_prio[a * FLD_PER_REG + f] = (d >> (2 * f)) & 3;
        end else if (a == REG_VBASE) m_vbase = d & ((1 << VBASE_W) - 1);
        else if (a >= REG_FAST0 && a < REG_PEND0) begin
            case ((a - REG_FAST0) % 3)
                0: m_match[(a - REG_FAST0) / 3] = d & 8'h7F;
                1: m_lo[(a - REG_FAST0) / 3]    = d & 16'hFFFF;
                default: m_hi[(a - REG_FAST0) / 3] = d & ((1 << HI_W) - 1);
            endcase
        end
    endfunction

    task automatic check_all();
        bit v, ir, req, fst;
        int lvl, idx, ea, a;
        string tag;
        ir = rst || m_hold != 0;
        calc_win(v, lvl, idx);
        req = v && lvl >= int'(core_mask) && !ir;
        chk("R4 irq_req", int'(irq_req), int'(req));
        if (req) begin
            chk("R3 irq_lvl", int'(irq_lvl), lvl);
            chk("R3 vec_num", int'(vec_num), idx + FIRST_VEC);
            ea = calc_addr(lvl, idx + FIRST_VEC, fst);
            chk(fst ? "R6 fast vec_addr" : "R5 table vec_addr", int'(vec_addr), ea);
        end
        if (ir) chk("R7 reset vec_addr", int'(vec_addr), int'(RST_A));
        a = int'(reg_addr);
        if (a < PRIO_REGS) tag = "R1 prio read";
        else if (a == REG_VBASE) tag = "R5 base read";
        else if (a < REG_PEND0) tag = "R6 slot read";
        else if (a < REG_LAST) tag = "R2 pending read";
        else if (a == REG_LAST) tag = "R8 status read";
        else tag = "R9 unmapped read";
        chk(tag, int'(reg_rdata), calc_read(a));
    endtask

    task automatic tick();
        bit v, ir, req;
        int lvl, idx;
        @(posedge clk);
        ir = rst || m_hold != 0;
        calc_win(v, lvl, idx);
        req = v && lvl >= int'(core_mask) && !ir;
        if (rst) m_reset();
        else begin
            if (core_ack && req) begin m_pend[idx] = 0; m_last = idx + FIRST_VEC; end
            for (int k = 0; k < NUM_SRC; k++) if (irq_in[k]) m_pend[k] = 1;
            if (reg_we) m_write(int'(reg_addr), int'(reg_wdata));
            if (m_hold > 0) m_hold--;
        end
        @(negedge clk);
        check_all();
    endtask

    task automatic wr(int a, int d);
        reg_we = 1'b1; reg_addr = REG_AW'(a); reg_wdata = DATA_W'(d);
        tick();
        reg_we = 1'b0;
    endtask

    task automatic pulse(int k);
        irq_in[k] = 1'b1;
        tick();
        irq_in = '0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_reset();
        @(negedge clk);
        // R7: reset state and post-release window
        repeat (3) tick();
        rst = 1'b0;
        irq_in[0] = 1'b1;
        tick();            // first edge after release: reset address still driven
        irq_in = '0;
        tick();            // second edge: window ends
        reg_addr = REG_AW'(REG_PEND0);
        tick();

        // R5, R1, R3: two level-1 sources, lowest vector wins
        wr(REG_VBASE, 16'h0123);
        wr(0, 16'h0088);   // sources 1 and 3 at code 10
        irq_in[1] = 1'b1; irq_in[3] = 1'b1;
        tick();
        irq_in = '0;
        core_mask = 2'd2;  // R4: blocked
        tick();
        core_mask = 2'd1;
        tick();
        // R3: level 2 source 60 outranks
        wr(7, 16'h0300);
        pulse(60);
        // R6: slot 1 then slot 0 both match vector 62
        wr(REG_FAST0 + 3, 62); wr(REG_FAST0 + 4, 16'hABCD); wr(REG_FAST0 + 5, 1);
        tick();
        wr(REG_FAST0, 62); wr(REG_FAST0 + 1, 16'h5555); wr(REG_FAST0 + 2, 0);
        tick();
        // R6: level 1 ignores fast slot
        wr(7, 16'h0200);
        tick();
        wr(7, 16'h0300);
        // R8: acknowledge, status
        reg_addr = REG_AW'(REG_LAST);
        core_ack = 1'b1; tick(); core_ack = 1'b0;
        tick();
        core_ack = 1'b1; tick(); core_ack = 1'b0;   // takes source 1
        // R8: ack while line re-pulses keeps pending
        irq_in[3] = 1'b1; core_ack = 1'b1; tick(); core_ack = 1'b0; irq_in = '0;
        reg_addr = REG_AW'(REG_PEND0);
        tick();
        // R9: writes to read-only and unmapped addresses
        wr(REG_PEND0, 16'hFFFF); reg_addr = REG_AW'(REG_PEND0); tick();
        wr(REG_LAST, 16'h007F); reg_addr = REG_AW'(REG_LAST); tick();
        wr(30, 16'hFFFF); reg_addr = REG_AW'(30); tick();
        // R4: mask 3 blocks all
        core_mask = 2'd3; tick(); core_ack = 1'b1; tick(); core_ack = 1'b0;
        core_mask = 2'd0; tick();

        // random phase
        for (int c = 0; c < 4000; c++) begin
            logic [95:0] r;
            r = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom}
              & {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom};
            irq_in   = NUM_SRC'(r);
            core_ack = ($urandom % 3) == 0;
            if (($urandom % 8) == 0) core_mask = 2'($urandom);
            reg_we   = ($urandom % 4) == 0;
            reg_addr = REG_AW'($urandom);
            if (($urandom % 4) == 0) reg_wdata = DATA_W'(FIRST_VEC + ($urandom % NUM_SRC));
            else                     reg_wdata = DATA_W'($urandom);
            tick();
        end
        irq_in = '0; reg_we = 1'b0; core_ack = 1'b0;

        // R7: reset again mid-run
        rst = 1'b1; tick(); tick();
        rst = 1'b0; tick(); tick(); tick();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule